// File: doc/BRIEF.md
# Power-On Strap Mode Latch

This block reads two boot straps once per power-on. It waits for power-on reset to be released, passes the strap pads through a synchronizer, and captures their levels a single time. It then holds the resulting boot-mode decisions until the next power-on reset. The boot logic reads two flags from the block: test mode and serial download mode. A third flag tells the boot logic that the decisions are valid.

Both straps are active low. A strap reading 1, which is the level the internal pull-ups give when nothing drives the pad, selects the normal path. A one-time-programmable lock bit can forbid download mode, whatever the download strap read.

Once the capture is complete, the pads are free for ordinary multiplexed use. Later pad activity does not reach the held decisions. This covers function traffic, wake-up edges and a warm reset.

Top module: `strap_mode_latch`

## Requirements
- R1: While `por_n` is low, `strap_valid_o`, `test_mode_o` and `dl_mode_o` are all 0.
- R2: With the default parameters, `strap_valid_o` is still 0 after the fourth rising clock edge that follows the release of `por_n`. It becomes 1 after the fifth such edge and stays 1 until `por_n` is asserted again.
- R3: Once valid, `test_mode_o` is 1 exactly when the test-inhibit strap (`strap_test_inh_i`) read 0 at capture. A strap reading of 1 gives `test_mode_o` = 0.
- R4: Once valid, with `otp_dl_lock_i` = 0, `dl_mode_o` is 1 exactly when the download-inhibit strap (`strap_dl_inh_i`) read 0 at capture.
- R5: While `otp_dl_lock_i` = 1, `dl_mode_o` is 0, whatever the captured download strap. Clearing the lock makes the captured strap visible again.
- R6: After valid, changes on either strap pad do not change `test_mode_o`, `dl_mode_o` or `strap_valid_o`.
- R7: `warm_rst_n` low after valid clears none of the outputs. `warm_rst_n` low before valid holds off the capture: `strap_valid_o` stays 0 while it is low.
- R8: Each new power-on reset discards the previous decisions and captures the strap levels present after that release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| por_n | input | 1 | Power-on reset, asynchronous assert, active low |
| warm_rst_n | input | 1 | Warm/soft reset, synchronous, active low; never clears held decisions |
| otp_dl_lock_i | input | 1 | Fuse bit; 1 forbids download mode |
| strap_test_inh_i | input | 1 | Test-inhibit strap pad, active low (0 = test mode) |
| strap_dl_inh_i | input | 1 | Download-inhibit strap pad, active low (0 = download) |
| strap_valid_o | output | 1 | Capture done; decisions below are meaningful |
| test_mode_o | output | 1 | Boot into test mode |
| dl_mode_o | output | 1 | Boot into serial download mode |

## Verification
The bench walks all eight combinations of the two straps and the lock bit through a fresh power-on. It samples the valid flag on both sides of the fifth edge, so a design that captures a cycle early, bypasses the synchronizer or never finishes the capture is caught. After every capture it inverts both pads and pulses the warm reset; a design that keeps sampling, for example from a wake-up edge, or that lets the warm reset clear the latch would change its flags there. Directed cases toggle the lock bit after capture to expose a design that latched the lock with the strap. They also hold warm reset through the fill window to expose a design that captures the pull-up value during that window.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int STRAP_W  = 2;
  localparam int IDX_TEST = 0;
  localparam int IDX_DL   = 1;

  typedef struct packed {
    logic valid;
    logic test;
    logic dl;
  } boot_mode_t;

endpackage

// File: rtl/strap_rst_sync.sv
// Asynchronous assert, synchronous release of the power-on reset.
module strap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/strap_pad_sync.sv
// Per-strap multi-flop synchronizer. Reset and warm reset load the pull-up level.
module strap_pad_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst_n,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      if (!warm_rst_n) sh_d = '1;
      else             sh_d = {sh_q[STAGES-2:0], pad_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= sh_d;
    end

    assign sync_o[b] = sh_q[STAGES-1];
  end

endmodule

// File: rtl/strap_capture.sv
// Waits for the synchronizer to fill, captures once, then locks.
module strap_capture #(
  parameter int W    = 2,
  parameter int FILL = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         warm_rst_n,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] held_o,
  output logic         done_o
);

  localparam int CW = $clog2(FILL + 1);
  localparam logic [CW-1:0] FILL_C = CW'(FILL);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  held_q, held_d;
  logic          done_q, done_d;
  logic          cnt_en, cap_en;

  always_comb begin
    cap_en = !done_q && warm_rst_n && (cnt_q == FILL_C);
    cnt_en = !done_q && !cap_en;
    cnt_d  = cnt_q;
    held_d = held_q;
    done_d = done_q;
    if (cnt_en) begin
      if (!warm_rst_n) cnt_d = '0;
      else             cnt_d = cnt_q + 1'b1;
    end
    if (cap_en) begin
      held_d = sync_i;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      held_q <= '1;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      held_q <= held_d;
      done_q <= done_d;
    end
  end

  assign held_o = held_q;
  assign done_o = done_q;

endmodule

// File: rtl/strap_decode.sv
// Turns held active-low straps and the fuse lock into boot flags.
module strap_decode
  import strap_pkg::*;
(
  input  logic [STRAP_W-1:0] held_i,
  input  logic               done_i,
  input  logic               otp_lock_i,
  output boot_mode_t         mode_o
);

  always_comb begin
    mode_o.valid = done_i;
    mode_o.test  = done_i && !held_i[IDX_TEST];
    mode_o.dl    = done_i && !held_i[IDX_DL] && !otp_lock_i;
  end

endmodule

// File: rtl/strap_mode_latch.sv
module strap_mode_latch
  import strap_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic warm_rst_n,
  input  logic otp_dl_lock_i,
  input  logic strap_test_inh_i,
  input  logic strap_dl_inh_i,
  output logic strap_valid_o,
  output logic test_mode_o,
  output logic dl_mode_o
);

  logic               rst_n;
  logic [STRAP_W-1:0] pads;
  logic [STRAP_W-1:0] pads_sync;
  logic [STRAP_W-1:0] held;
  logic               done;
  boot_mode_t         mode;

  always_comb begin
    pads           = '1;
    pads[IDX_TEST] = strap_test_inh_i;
    pads[IDX_DL]   = strap_dl_inh_i;
  end

  strap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .por_n   (por_n),
    .rst_n_o (rst_n)
  );

  strap_pad_sync #(.W(STRAP_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .pad_i      (pads),
    .sync_o     (pads_sync)
  );

  strap_capture #(.W(STRAP_W), .FILL(SYNC_STAGES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_rst_n (warm_rst_n),
    .sync_i     (pads_sync),
    .held_o     (held),
    .done_o     (done)
  );

  strap_decode u_dec (
    .held_i     (held),
    .done_i     (done),
    .otp_lock_i (otp_dl_lock_i),
    .mode_o     (mode)
  );

  assign strap_valid_o = mode.valid;
  assign test_mode_o   = mode.test;
  assign dl_mode_o     = mode.dl;

endmodule

// File: rtl/strap_mode_latch_chk.sv
module strap_mode_latch_chk (
  input logic clk,
  input logic por_n,
  input logic warm_rst_n,
  input logic otp_dl_lock_i,
  input logic strap_valid_o,
  input logic test_mode_o,
  input logic dl_mode_o
);

  // R1: outputs quiet while power-on reset is held
  always_ff @(posedge clk) begin
    if (por_n === 1'b0) begin
      assert_reset_quiet_R1: assert (!strap_valid_o && !test_mode_o && !dl_mode_o)
        else $error("R1 outputs active during power-on reset");
    end
  end

  assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (!por_n)
    strap_valid_o |=> strap_valid_o);

  assert_test_held_R6: assert property (@(posedge clk) disable iff (!por_n)
    strap_valid_o |=> $stable(test_mode_o));

  assert_dl_held_R6: assert property (@(posedge clk) disable iff (!por_n)
    (strap_valid_o && otp_dl_lock_i == $past(otp_dl_lock_i)) |-> $stable(dl_mode_o) || $rose(strap_valid_o));

  assert_lock_blocks_R5: assert property (@(posedge clk) disable iff (!por_n)
    otp_dl_lock_i |-> !dl_mode_o);

  assert_warm_hold_R7: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n && !strap_valid_o |=> !strap_valid_o);

  assert_warm_keep_R7: assert property (@(posedge clk) disable iff (!por_n)
    !warm_rst_n && strap_valid_o |=> strap_valid_o);

endmodule

bind strap_mode_latch strap_mode_latch_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .warm_rst_n    (warm_rst_n),
  .otp_dl_lock_i (otp_dl_lock_i),
  .strap_valid_o (strap_valid_o),
  .test_mode_o   (test_mode_o),
  .dl_mode_o     (dl_mode_o)
);

// File: tb/strap_mode_latch_tb.sv
module strap_mode_latch_tb;

  logic clk = 1'b0;
  logic por_n = 1'b1;
  logic warm_rst_n = 1'b1;
  logic otp_dl_lock_i = 1'b0;
  logic strap_test_inh_i = 1'b1;
  logic strap_dl_inh_i = 1'b1;
  logic strap_valid_o, test_mode_o, dl_mode_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  strap_mode_latch u_dut (
    .clk              (clk),
    .por_n            (por_n),
    .warm_rst_n       (warm_rst_n),
    .otp_dl_lock_i    (otp_dl_lock_i),
    .strap_test_inh_i (strap_test_inh_i),
    .strap_dl_inh_i   (strap_dl_inh_i),
    .strap_valid_o    (strap_valid_o),
    .test_mode_o      (test_mode_o),
    .dl_mode_o        (dl_mode_o)
  );

  // {test strap, dl strap, lock, expected test_mode, expected dl_mode}
  localparam logic [4:0] VEC [8] = '{
    5'b11_0_00, 5'b10_0_01, 5'b01_0_10, 5'b00_0_11,
    5'b11_1_00, 5'b10_1_00, 5'b01_1_10, 5'b00_1_10
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Power-on with given pads; checks reset quiet state and capture timing.
  task automatic power_on(logic t, logic d, logic l);
    por_n = 1'b0;
    strap_test_inh_i = t;
    strap_dl_inh_i = d;
    otp_dl_lock_i = l;
    cyc(3);
    chk("R1 valid in reset", strap_valid_o, 0);
    chk("R1 flags in reset", {test_mode_o, dl_mode_o}, 0);
    por_n = 1'b1;
    cyc(4);
    chk("R2 not valid after 4 edges", strap_valid_o, 0);
    cyc(1);
    chk("R2 valid after 5 edges", strap_valid_o, 1);
  endtask

  initial begin
    #1 por_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      logic [4:0] v;
      v = VEC[i];
      power_on(v[4], v[3], v[2]);
      chk("R3 test_mode", test_mode_o, v[1]);
      chk(v[2] ? "R5 dl_mode locked" : "R4 dl_mode", dl_mode_o, v[0]);
      chk("R8 recapture", {test_mode_o, dl_mode_o}, {v[1], v[0]});
      strap_test_inh_i = ~v[4];
      strap_dl_inh_i = ~v[3];
      cyc(4);
      chk("R6 flags after pad toggle", {strap_valid_o, test_mode_o, dl_mode_o}, {1'b1, v[1], v[0]});
      warm_rst_n = 1'b0;
      cyc(3);
      warm_rst_n = 1'b1;
      cyc(3);
      chk("R7 flags after warm reset", {strap_valid_o, test_mode_o, dl_mode_o}, {1'b1, v[1], v[0]});
    end

    // R5: lock applied and removed after capture of an active download strap
    power_on(1'b1, 1'b0, 1'b0);
    chk("R4 dl active", dl_mode_o, 1);
    otp_dl_lock_i = 1'b1;
    cyc(1);
    chk("R5 lock forces normal boot", dl_mode_o, 0);
    otp_dl_lock_i = 1'b0;
    cyc(1);
    chk("R5 unlock restores strap", dl_mode_o, 1);

    // R7: warm reset held across fill window delays capture
    por_n = 1'b0;
    strap_test_inh_i = 1'b1;
    strap_dl_inh_i = 1'b1;
    warm_rst_n = 1'b0;
    cyc(3);
    por_n = 1'b1;
    cyc(10);
    chk("R7 no capture under warm reset", strap_valid_o, 0);
    strap_test_inh_i = 1'b0;
    strap_dl_inh_i = 1'b0;
    cyc(2);
    warm_rst_n = 1'b1;
    cyc(6);
    chk("R7 capture after warm release", strap_valid_o, 1);
    chk("R3 late test capture", test_mode_o, 1);
    chk("R4 late dl capture", dl_mode_o, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule